// File: doc/BRIEF.md
# Linear Systolic Gauss-Jordan Solver

This block solves a dense linear system A·x = b in signed fixed point. It is a one-dimensional chain of N processing elements (PEs), each owning one elimination step. The augmented matrix [A | b] enters one word per clock, one column after another. The solution vector leaves the last PE in row order. There is no central sequencer. A 2-bit tag travels beside every word and tells each PE what to do with it. The PEs rewrite these tags as the words pass through, so that the next PE receives the stream in the form it expects.

PE k keeps the first column that reaches it as its pivot column. It holds the diagonal element as the pivot and writes the remaining elements into a small circular store as row multipliers. It does not forward that column. For every later column, PE k takes the first element it receives, which is the pivot-row element, and divides it by the pivot to form a quotient. It then replaces each following element with that element minus its stored multiplier times the quotient, rereading the circular store once per column. In the idle slot after the column, it emits the quotient itself. This rotates the row order by one place, so the next PE sees its own pivot row first. Only the right-hand-side column survives all N PEs, and it arrives as the solution.

Top module: `gj_systolic_array`

## Requirements
- R1: While reset is asserted, and afterwards until a solution is due, `out_valid` is low.
- R2: For each problem, the last PE emits exactly N valid words. These are x1 to xN, in row order, on consecutive clocks.
- R3: If the first word of the right-hand-side column is accepted on clock edge P, the word for xi (i counted from 0) leaves on edge P+2N-1+i.
- R4: Input format. Columns enter in order 1 to N+1, and within a column rows enter in order 1 to N. Each column is followed by at least one slot with `in_valid` low. Tag codes:
  - Column 1 uses 01 (pivot load) on its first word and 11 (multiplier load) on its other words.
  - Every later column uses 00 (normalise) on its first word and 10 (eliminate) on its other words.
- R5: Words are W-bit two's complement with F fraction bits. The quotient is (a·2^F)/d, truncated toward zero. A product is (e·c) shifted right arithmetically by F bits. Every result wraps to W bits.
- R6: A zero pivot gives a quotient of zero instead of an undefined value.
- R7: A new problem may start in the slot right after the last idle slot of the previous problem. Both problems are then solved correctly.
- R8: Additional idle slots between columns shift the output in time only, following the R3 rule, and leave the values unchanged.
- R9: `out_valid` is high only for the solution words of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word present; low marks an idle slot |
| in_tag | input | 2 | Operation tag for the input word (R4 codes) |
| in_data | input | W | Matrix or right-hand-side element, fixed point |
| out_valid | output | 1 | Solution word present |
| out_tag | output | 2 | Tag of the word leaving the last PE (01 first, then 11) |
| out_data | output | W | Solution element, fixed point |

## Verification
The bench goes after the clock on which each solution word appears. An error in the row rotation, or in the slot where a quotient is held back, would shift or reorder the outputs and break the every-clock comparison. Negative operands and fractional quotients check the division truncation and the product rounding, where a divider that rounded, or a shift that did not keep the sign, would drift by one LSB. A zero pivot on the first diagonal element must yield a zero row instead of an undefined value. Back-to-back problems and widened idle gaps catch a PE that misses the tag telling it to reload its pivot, or that fires its quotient into the wrong slot.

// File: rtl/gj_pkg.sv
package gj_pkg;

  typedef enum logic [1:0] {
    TAG_NORM = 2'b00,
    TAG_PIV  = 2'b01,
    TAG_ELIM = 2'b10,
    TAG_MUL  = 2'b11
  } gj_tag_e;

  typedef enum logic [1:0] {
    PH_PIVOT = 2'b00,
    PH_FIRST = 2'b01,
    PH_REST  = 2'b10
  } gj_phase_e;

endpackage

// File: rtl/gj_mult_store.sv
module gj_mult_store #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_wr,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         clr_rd,
  input  logic         rd_en,
  output logic [W-1:0] rd_data
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW:0]   fill_q, fill_d;
  logic [AW-1:0] rd_q, rd_d;
  logic [AW:0]   rd_inc;
  logic          do_wr;

  assign do_wr  = wr_en && !clr_wr && (fill_q < DEPTH_C);
  assign rd_inc = {1'b0, rd_q} + (AW+1)'(1);

  always_comb begin
    fill_d = fill_q;
    rd_d   = rd_q;
    if (clr_wr)     fill_d = '0;
    else if (do_wr) fill_d = fill_q + (AW+1)'(1);
    if (clr_rd)     rd_d = '0;
    else if (rd_en) rd_d = (rd_inc >= fill_q) ? '0 : rd_inc[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      rd_q   <= '0;
    end else begin
      fill_q <= fill_d;
      rd_q   <= rd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[fill_q[AW-1:0]] <= wr_data;
  end

  assign rd_data = mem[rd_q];

  AST_STORE_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr_wr) |-> (fill_q < DEPTH_C)); // R4

endmodule

// File: rtl/gj_pe.sv
module gj_pe
  import gj_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 16,
  parameter int F = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [1:0]   in_tag,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [1:0]   out_tag,
  output logic [W-1:0] out_data
);

  localparam int DW = 2 * W;

  gj_tag_e   tag_i;
  logic [W-1:0] d_q, d_n, c_q, c_n, od_q, od_n, e_val;
  logic      pend_q, pend_n, lead_q, lead_n, ov_q, ov_n;
  gj_phase_e phase_q, phase_n;
  gj_tag_e   ot_q, ot_n;
  logic      st_wr, st_clr_wr, st_rd, st_clr_rd;

  logic signed [DW-1:0] num_w, den_w, e_w, c_w;
  logic signed [W-1:0]  quot, shf, diff;

  assign tag_i = gj_tag_e'(in_tag);

  gj_mult_store #(.W(W), .DEPTH(N)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_wr  (st_clr_wr),
    .wr_en   (st_wr),
    .wr_data (in_data),
    .clr_rd  (st_clr_rd),
    .rd_en   (st_rd),
    .rd_data (e_val)
  );

  // arithmetic datapath
  always_comb begin
    num_w = DW'($signed(in_data));
    num_w = num_w <<< F;
    den_w = DW'($signed(d_q));
    quot  = (d_q == '0) ? '0 : W'(num_w / den_w);
    e_w   = DW'($signed(e_val));
    c_w   = DW'($signed(c_q));
    shf   = W'((e_w * c_w) >>> F);
    diff  = $signed(in_data) - shf;
  end

  // next state
  always_comb begin
    d_n       = d_q;
    c_n       = c_q;
    pend_n    = pend_q;
    lead_n    = lead_q;
    phase_n   = phase_q;
    ov_n      = 1'b0;
    ot_n      = ot_q;
    od_n      = od_q;
    st_wr     = 1'b0;
    st_clr_wr = 1'b0;
    st_rd     = 1'b0;
    st_clr_rd = 1'b0;
    if (in_valid) begin
      case (tag_i)
        TAG_PIV: begin
          d_n       = in_data;
          phase_n   = PH_PIVOT;
          st_clr_wr = 1'b1;
        end
        TAG_MUL: st_wr = 1'b1;
        TAG_NORM: begin
          c_n       = quot;
          pend_n    = 1'b1;
          lead_n    = 1'b1;
          st_clr_rd = 1'b1;
        end
        TAG_ELIM: begin
          st_rd  = 1'b1;
          ov_n   = 1'b1;
          od_n   = diff;
          lead_n = 1'b0;
          if (lead_q) ot_n = (phase_q == PH_FIRST) ? TAG_PIV : TAG_NORM;
          else        ot_n = (phase_q == PH_FIRST) ? TAG_MUL : TAG_ELIM;
        end
      endcase
    end else if (pend_q) begin
      ov_n   = 1'b1;
      od_n   = c_q;
      ot_n   = (phase_q == PH_FIRST) ? TAG_MUL : TAG_ELIM;
      pend_n = 1'b0;
      if (phase_q == PH_FIRST) phase_n = PH_REST;
    end else if (phase_q == PH_PIVOT) begin
      phase_n = PH_FIRST;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q     <= '0;
      c_q     <= '0;
      pend_q  <= 1'b0;
      lead_q  <= 1'b0;
      phase_q <= PH_PIVOT;
      ov_q    <= 1'b0;
      ot_q    <= TAG_NORM;
      od_q    <= '0;
    end else begin
      d_q     <= d_n;
      c_q     <= c_n;
      pend_q  <= pend_n;
      lead_q  <= lead_n;
      phase_q <= phase_n;
      ov_q    <= ov_n;
      if (ov_n) begin
        ot_q <= ot_n;
        od_q <= od_n;
      end
    end
  end

  assign out_valid = ov_q;
  assign out_tag   = ot_q;
  assign out_data  = od_q;

  AST_PIVOT_COL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_tag == TAG_PIV || in_tag == TAG_MUL)) |=> !out_valid); // R4
  AST_NORM_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_tag == TAG_NORM) |=> !out_valid); // R3
  AST_ELIM_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_tag == TAG_ELIM) |=> out_valid); // R3
  AST_ELIM_HAS_QUOTIENT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_tag == TAG_ELIM) |-> pend_q); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !pend_q) |=> !out_valid); // R9
  AST_ZERO_PIVOT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_tag == TAG_NORM && d_q == '0) |=> (c_q == '0)); // R6

endmodule

// File: rtl/gj_systolic_array.sv
module gj_systolic_array #(
  parameter int N = 4,
  parameter int W = 16,
  parameter int F = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [1:0]   in_tag,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [1:0]   out_tag,
  output logic [W-1:0] out_data
);

  localparam int STAGES = N + 1;

  logic         v_s [STAGES];
  logic [1:0]   t_s [STAGES];
  logic [W-1:0] d_s [STAGES];

  assign v_s[0] = in_valid;
  assign t_s[0] = in_tag;
  assign d_s[0] = in_data;

  for (genvar k = 0; k < N; k++) begin : g_pe
    gj_pe #(.N(N), .W(W), .F(F)) u_pe (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (v_s[k]),
      .in_tag    (t_s[k]),
      .in_data   (d_s[k]),
      .out_valid (v_s[k+1]),
      .out_tag   (t_s[k+1]),
      .out_data  (d_s[k+1])
    );
  end

  assign out_valid = v_s[N];
  assign out_tag   = t_s[N];
  assign out_data  = d_s[N];

endmodule

// File: tb/gj_systolic_array_bench.sv
module gj_systolic_array_bench;

  localparam int N = 4;
  localparam int W = 16;
  localparam int F = 8;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [1:0]   in_tag;
  logic [W-1:0] in_data;
  logic         out_valid;
  logic [1:0]   out_tag;
  logic [W-1:0] out_data;

  gj_systolic_array #(.N(N), .W(W), .F(F)) u_gj_systolic_array (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
    .in_data(in_data), .out_valid(out_valid), .out_tag(out_tag), .out_data(out_data)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit chk_on = 0;
  bit done   = 0;

  longint mat [N][N+1];
  longint wk  [N][N+1];
  longint cvec [N+1];

  int     exp_cyc [$];
  longint exp_val [$];
  string  exp_req [$];

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint wrap(longint v);
    longint m;
    m = v & ((64'sd1 <<< W) - 1);
    if (m >= (64'sd1 <<< (W-1))) m = m - (64'sd1 <<< W);
    return m;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, expv);
    end
  endtask

  // every-clock comparison against the expected output schedule (R2 R3 R9)
  always @(negedge clk) begin
    if (chk_on) begin
      if (exp_cyc.size() > 0 && exp_cyc[0] == cyc) begin
        chk(out_valid == 1'b1, {exp_req[0], " valid"}, longint'(out_valid), 1);
        chk(longint'($signed(out_data)) == exp_val[0], {exp_req[0], " value"},
            longint'($signed(out_data)), exp_val[0]);
        void'(exp_cyc.pop_front());
        void'(exp_val.pop_front());
        void'(exp_req.pop_front());
      end else begin
        chk(out_valid == 1'b0, "R9 no stray output", longint'(out_valid), 0);
      end
    end
  end

  task automatic send(bit v, logic [1:0] t, longint d, output int at);
    @(negedge clk);
    in_valid = v;
    in_tag   = t;
    in_data  = W'(d);
    at       = cyc;
  endtask

  task automatic gen_random();
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (i == j) begin
          mat[i][j] = longint'($urandom_range(4*256, 6*256));
          if ($urandom_range(0, 1) == 1) mat[i][j] = -mat[i][j];
        end else begin
          mat[i][j] = longint'($urandom_range(0, 512)) - 256;
        end
      end
      mat[i][N] = longint'($urandom_range(0, 1024)) - 512;
    end
  endtask

  // behavioural fixed-point Gauss-Jordan (R5, R6)
  task automatic ref_solve();
    longint piv;
    for (int i = 0; i < N; i++)
      for (int j = 0; j <= N; j++) wk[i][j] = mat[i][j];
    for (int k = 0; k < N; k++) begin
      piv = wk[k][k];
      for (int j = k+1; j <= N; j++)
        cvec[j] = (piv == 0) ? 0 : wrap((wk[k][j] <<< F) / piv);
      for (int i = 0; i < N; i++)
        if (i != k)
          for (int j = k+1; j <= N; j++)
            wk[i][j] = wrap(wk[i][j] - wrap((wk[i][k] * cvec[j]) >>> F));
      for (int j = k+1; j <= N; j++) wk[k][j] = cvec[j];
    end
  endtask

  // R4 input format: column 1 tagged 01/11, later columns 00/10, idle slot after each
  task automatic run_problem(int gap, string req);
    int at;
    int c0;
    logic [1:0] t;
    ref_solve();
    c0 = 0;
    for (int j = 0; j <= N; j++) begin
      for (int i = 0; i < N; i++) begin
        if (j == 0) t = (i == 0) ? 2'b01 : 2'b11;
        else        t = (i == 0) ? 2'b00 : 2'b10;
        send(1'b1, t, mat[i][j], at);
        if (j == N && i == 0) c0 = at;
      end
      for (int g = 0; g < gap; g++) send(1'b0, 2'b00, 0, at);
    end
    for (int i = 0; i < N; i++) begin
      exp_cyc.push_back(c0 + 2*N + i);
      exp_val.push_back(wk[i][N]);
      exp_req.push_back({req, "/R3"});
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    int at;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_tag   = 2'b00;
    in_data  = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 reset quiet", longint'(out_valid), 0);
    rst_n  = 1'b1;
    chk_on = 1'b1;
    repeat (5) send(1'b0, 2'b00, 0, at);   // R1 idle after reset, checked each clock

    for (int t = 0; t < 3; t++) begin
      gen_random();
      run_problem(1, "R2/R4/R5");
    end
    gen_random();
    run_problem(1, "R7");
    gen_random();
    run_problem(1, "R7");
    gen_random();
    run_problem(3, "R8");
    gen_random();
    mat[0][0] = 0;
    run_problem(1, "R6");

    repeat (4*N + 10) send(1'b0, 2'b00, 0, at);
    chk(exp_cyc.size() == 0, "R2 all solution words seen", exp_cyc.size(), 0);
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d: actual 0 expected 1", cyc);
      finish_run();
    end
  end

endmodule